// File: doc/BRIEF.md
# Serial Display Command Receiver

This block is the receiving end of a three-wire serial link that loads a dot-matrix character display. A host holds a load strobe low, presents one data bit per rising edge of a serial clock, least significant bit first, and then releases the strobe. When the strobe rises, the byte is split into a 3-bit opcode (bits 7..5) and a 5-bit payload (bits 4..0). The opcode decides where the payload goes: a row of the column memory, the character address register, or the control word register.

The column memory holds 10 characters of 5 rows with 5 column bits each. Row writes land at the character address that an earlier command latched. A display multiplexer reads the memory through a separate combinational read port at any time, with no handshake against the writes. The three serial inputs are asynchronous. They cross into the system clock domain through flop synchronisers, and their edges are detected there.

The character address and the control word are visible as outputs. The multiplexer, the oscillator and the LED drivers sit outside this block.

Top module: `sdisp_cmd_rx`

## Requirements
- R1: Bits are captured only on a rising edge of the serial clock while the load strobe is low. Data changes while the clock is high, and clock edges while the strobe is high, leave every output unchanged.
- R2: The first bit received becomes bit 0 of the byte, so byte 8'hA1 sent bit 0 first loads character address 1.
- R3: A byte takes effect only after the load strobe rises. It is visible on the outputs within 6 system clock cycles of the rise at the pin, and never while the strobe is still low.
- R4: Opcodes 3'b000 to 3'b100 write the payload into rows 0 to 4, at the latched character address. The row index equals the opcode value.
- R5: Opcode 3'b101 latches the 5-bit payload into the character address register, shown on cur_addr_o.
- R6: Opcodes 3'b110 and 3'b111 latch the payload into the control word register, shown on ctrl_word_o.
- R7: While the latched character address is 10 or greater, row write commands change no memory cell.
- R8: A strobe window holding any number of clock edges other than eight is discarded: no register or memory cell changes.
- R9: The read port returns the 5 stored column bits for character rd_char_i and row rd_row_i combinationally. It returns 0 when the character is 10 or more or the row is 5 or more.
- R10: Reset clears every memory cell, the character address and the control word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe, asynchronous; low while a byte is shifted in |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data, bit 0 first |
| rd_char_i | input | 4 | Read port character index |
| rd_row_i | input | 3 | Read port row index |
| rd_cols_o | output | 5 | Column bits of the addressed cell |
| ctrl_word_o | output | 5 | Control word register |
| cur_addr_o | output | 5 | Latched character address |

## Verification
On every cycle, the assertions check that a byte commits only on a detected strobe rise and that at most one destination is written per commit. They also check that each register changes only when its own write enable fires and then takes the committed payload, and that no memory write happens while the address is out of range. Only the bench's scenarios can show the serial-side behaviour: bit order, sampling on the clock's rising edge, and discarding of short and long windows. The same holds for the memory contents after each command sequence and the full clear on a reset mid-run.

// File: rtl/sdisp_pkg.sv
`timescale 1ns/1ps
package sdisp_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 3;
  localparam int PAY_W  = 5;

  localparam logic [OP_W-1:0] OPC_CHAR = 3'b101;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RAM  = 2'd1,
    DST_ADDR = 2'd2,
    DST_CTRL = 2'd3
  } dest_e;

  // opcode to destination; row opcodes run from zero up to rows-1
  function automatic dest_e op_dest(input logic [OP_W-1:0] op, input int rows);
    if (int'(op) < rows)       return DST_RAM;
    else if (op == OPC_CHAR)   return DST_ADDR;
    else if (op[2:1] == 2'b11) return DST_CTRL;
    else                       return DST_NONE;
  endfunction

  function automatic logic addr_writable(input logic [PAY_W-1:0] addr, input int chars);
    return int'(addr) < chars;
  endfunction

  function automatic int cell_index(input int chr, input int row, input int rows);
    return chr * rows + row;
  endfunction
endpackage

// File: rtl/sdisp_sync.sv
`timescale 1ns/1ps
module sdisp_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RESET_VAL;
        else        chain_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RESET_VAL;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sdisp_shifter.sv
`timescale 1ns/1ps
module sdisp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_s,
  input  logic            sclk_s,
  input  logic            data_s,
  output logic            load_rise_o,
  output logic            commit_o,
  output logic [BITS-1:0] byte_o
);
  localparam int             CNT_W    = $clog2(BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BITS + 1);

  logic             load_q, sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;
  logic             sclk_rise, load_fall, shift_en;

  assign sclk_rise   = sclk_s & ~sclk_q;
  assign load_rise_o = load_s & ~load_q;
  assign load_fall   = ~load_s & load_q;
  assign shift_en    = sclk_rise & ~load_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      load_q <= load_s;
      sclk_q <= sclk_s;
    end
  end

  // count restarts on every strobe fall; saturates one past a full byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (load_fall)                      cnt_q <= shift_en ? CNT_W'(1) : '0;
    else if (shift_en && cnt_q != CNT_OVER)  cnt_q <= cnt_q + 1'b1;
  end

  // first bit in ends up at bit 0 after BITS shifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= {data_s, sh_q[BITS-1:1]};
  end

  assign commit_o = load_rise_o && (cnt_q == CNT_FULL);
  assign byte_o   = sh_q;
endmodule

// File: rtl/sdisp_decode.sv
`timescale 1ns/1ps
module sdisp_decode
  import sdisp_pkg::*;
#(
  parameter int NUM_CHARS = 10,
  parameter int NUM_ROWS  = 5
) (
  input  logic              commit,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic [PAY_W-1:0]  cur_addr,
  output logic              ram_we,
  output logic              addr_we,
  output logic              ctrl_we,
  output logic [OP_W-1:0]   row_o,
  output logic [PAY_W-1:0]  payload_o
);
  dest_e dest;

  assign row_o     = data_byte[BYTE_W-1 -: OP_W];
  assign payload_o = data_byte[PAY_W-1:0];
  assign dest      = op_dest(row_o, NUM_ROWS);

  assign ram_we  = commit && (dest == DST_RAM) && addr_writable(cur_addr, NUM_CHARS);
  assign addr_we = commit && (dest == DST_ADDR);
  assign ctrl_we = commit && (dest == DST_CTRL);
endmodule

// File: rtl/sdisp_colram.sv
`timescale 1ns/1ps
module sdisp_colram
  import sdisp_pkg::*;
#(
  parameter int CHARS = 10,
  parameter int ROWS  = 5,
  parameter int COLS  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(CHARS)-1:0] wr_char,
  input  logic [$clog2(ROWS)-1:0]  wr_row,
  input  logic [COLS-1:0]          wr_data,
  input  logic [$clog2(CHARS)-1:0] rd_char,
  input  logic [$clog2(ROWS)-1:0]  rd_row,
  output logic [COLS-1:0]          rd_data
);
  localparam int NCELLS = CHARS * ROWS;

  logic [COLS-1:0] cell_q [NCELLS];
  int              wr_idx, rd_idx;
  logic            rd_ok;

  assign wr_idx = cell_index(int'(wr_char), int'(wr_row), ROWS);
  assign rd_idx = cell_index(int'(rd_char), int'(rd_row), ROWS);
  assign rd_ok  = (int'(rd_char) < CHARS) && (int'(rd_row) < ROWS);

  for (genvar g = 0; g < NCELLS; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cell_q[g] <= '0;
      else if (we && (wr_idx == g))   cell_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCELLS; i++) begin
      if (rd_ok && (rd_idx == i)) rd_data = cell_q[i];
    end
  end
endmodule

// File: rtl/sdisp_cmd_rx.sv
`timescale 1ns/1ps
module sdisp_cmd_rx
  import sdisp_pkg::*;
#(
  parameter int NUM_CHARS   = 10,
  parameter int NUM_ROWS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic                         sclk_i,
  input  logic                         sdata_i,
  input  logic [$clog2(NUM_CHARS)-1:0] rd_char_i,
  input  logic [$clog2(NUM_ROWS)-1:0]  rd_row_i,
  output logic [PAY_W-1:0]             rd_cols_o,
  output logic [PAY_W-1:0]             ctrl_word_o,
  output logic [PAY_W-1:0]             cur_addr_o
);
  localparam int CHAR_W = $clog2(NUM_CHARS);
  localparam int ROW_W  = $clog2(NUM_ROWS);

  // named internal events, observed by the bound checker
  logic              load_s, sclk_s, data_s;
  logic              load_rise_w, commit_w;
  logic [BYTE_W-1:0] byte_w;
  logic              ram_we_w, addr_we_w, ctrl_we_w;
  logic [OP_W-1:0]   row_w;
  logic [PAY_W-1:0]  payload_w;
  logic [PAY_W-1:0]  addr_q, ctrl_q;

  sdisp_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({load_i, sclk_i, sdata_i}),
    .dout ({load_s, sclk_s, data_s})
  );

  sdisp_shifter #(.BITS(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_s     (load_s),
    .sclk_s     (sclk_s),
    .data_s     (data_s),
    .load_rise_o(load_rise_w),
    .commit_o   (commit_w),
    .byte_o     (byte_w)
  );

  sdisp_decode #(.NUM_CHARS(NUM_CHARS), .NUM_ROWS(NUM_ROWS)) u_dec (
    .commit   (commit_w),
    .data_byte(byte_w),
    .cur_addr (addr_q),
    .ram_we   (ram_we_w),
    .addr_we  (addr_we_w),
    .ctrl_we  (ctrl_we_w),
    .row_o    (row_w),
    .payload_o(payload_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_we_w) addr_q <= payload_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_we_w) ctrl_q <= payload_w;
  end

  sdisp_colram #(.CHARS(NUM_CHARS), .ROWS(NUM_ROWS), .COLS(PAY_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ram_we_w),
    .wr_char(addr_q[CHAR_W-1:0]),
    .wr_row (row_w[ROW_W-1:0]),
    .wr_data(payload_w),
    .rd_char(rd_char_i),
    .rd_row (rd_row_i),
    .rd_data(rd_cols_o)
  );

  assign ctrl_word_o = ctrl_q;
  assign cur_addr_o  = addr_q;
endmodule

// File: rtl/sdisp_cmd_rx_chk.sv
`timescale 1ns/1ps
module sdisp_cmd_rx_chk #(
  parameter int NUM_CHARS = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       load_rise,
  input logic       commit,
  input logic       ram_we,
  input logic       addr_we,
  input logic       ctrl_we,
  input logic [4:0] payload,
  input logic [4:0] cur_addr,
  input logic [4:0] ctrl_word
);
  p_commit_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> load_rise);

  p_single_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, addr_we, ctrl_we}));

  p_we_needs_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || addr_we || ctrl_we) |-> commit);

  p_addr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (cur_addr == $past(payload)));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(cur_addr));

  p_ctrl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_word == $past(payload)));

  p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_word));

  p_ram_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (int'(cur_addr) < NUM_CHARS));
endmodule

bind sdisp_cmd_rx sdisp_cmd_rx_chk #(.NUM_CHARS(NUM_CHARS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_rise(load_rise_w),
  .commit   (commit_w),
  .ram_we   (ram_we_w),
  .addr_we  (addr_we_w),
  .ctrl_we  (ctrl_we_w),
  .payload  (payload_w),
  .cur_addr (cur_addr_o),
  .ctrl_word(ctrl_word_o)
);

// File: tb/sdisp_cmd_rx_test.sv
`timescale 1ns/1ps
module sdisp_cmd_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic [3:0] rd_char = '0;
  logic [2:0] rd_row = '0;
  logic [4:0] rd_cols, ctrl_word, cur_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int m_mem [10][5];
  int m_addr, m_ctrl;

  always #2 clk = ~clk;

  sdisp_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .sclk_i(sclk), .sdata_i(sdat),
    .rd_char_i(rd_char), .rd_row_i(rd_row), .rd_cols_o(rd_cols),
    .ctrl_word_o(ctrl_word), .cur_addr_o(cur_addr)
  );

  // entry: {byte, clock edges in window, requirement number}
  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    {8'hA1, 4'd8, 4'd2},  // R2: bit 0 first -> address 1
    {8'hA3, 4'd8, 4'd5},  // R5
    {8'h1E, 4'd8, 4'd4},  // R4 row 0
    {8'h31, 4'd8, 4'd4},  // R4 row 1
    {8'h51, 4'd8, 4'd4},  // R4 row 2
    {8'h71, 4'd8, 4'd4},  // R4 row 3
    {8'h9E, 4'd8, 4'd4},  // R4 row 4
    {8'hC9, 4'd8, 4'd6},  // R6 opcode 110
    {8'hF5, 4'd8, 4'd6},  // R6 opcode 111
    {8'hA9, 4'd8, 4'd5},  // R5 last character
    {8'h5F, 4'd8, 4'd4},  // R4
    {8'hAC, 4'd8, 4'd7},  // R7 address 12
    {8'h0F, 4'd8, 4'd7},  // R7 write ignored
    {8'hBF, 4'd8, 4'd7},  // R7 address 31
    {8'h9F, 4'd8, 4'd7},  // R7 write ignored
    {8'hA0, 4'd8, 4'd5},  // R5
    {8'h3F, 4'd7, 4'd8},  // R8 short
    {8'h3F, 4'd9, 4'd8},  // R8 long
    {8'hA6, 4'd7, 4'd8},  // R8 short address load
    {8'h3F, 4'd0, 4'd8},  // R8 bare strobe
    {8'h3F, 4'd8, 4'd4},  // R4
    {8'hE0, 4'd8, 4'd6}   // R6
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 10; c++) for (int r = 0; r < 5; r++) m_mem[c][r] = 0;
    m_addr = 0;
    m_ctrl = 0;
  endtask

  task automatic model_apply(input logic [7:0] b, input int nbits);
    int op;
    op = int'(b[7:5]);
    if (nbits == 8) begin
      if (op < 5) begin
        if (m_addr < 10) m_mem[m_addr][op] = int'(b[4:0]);
      end else if (op == 5) m_addr = int'(b[4:0]);
      else m_ctrl = int'(b[4:0]);
    end
  endtask

  task automatic shift_bits(input logic [7:0] b, input int nbits, input bit glitch);
    load = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) sdat = b[i];
      else       sdat = 1'b1;
      tick(3);
      sclk = 1'b1;
      tick(1);
      if (glitch) sdat = ~sdat;
      tick(2);
      sclk = 1'b0;
      tick(3);
    end
  endtask

  task automatic send(input logic [7:0] b, input int nbits, input bit glitch);
    shift_bits(b, nbits, glitch);
    load = 1'b1;
    tick(6);
    model_apply(b, nbits);
  endtask

  task automatic check_ram(input string tag);
    int bad = 0, first_act = 0, first_exp = 0;
    for (int c = 0; c < 10; c++) begin
      for (int r = 0; r < 5; r++) begin
        @(negedge clk);
        rd_char = 4'(c);
        rd_row  = 3'(r);
        #1;
        if (int'(rd_cols) != m_mem[c][r]) begin
          if (bad == 0) begin first_act = int'(rd_cols); first_exp = m_mem[c][r]; end
          bad++;
        end
      end
    end
    chk(tag, "column memory (first mismatching cell)", bad == 0 ? first_exp : first_act, first_exp);
  endtask

  task automatic check_regs(input string tag);
    chk(tag, "cur_addr_o", int'(cur_addr), m_addr);
    chk(tag, "ctrl_word_o", int'(ctrl_word), m_ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R10: state after reset
    check_regs("R10");
    check_ram("R10");

    // table walk
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", int'(VEC[k][3:0]), k);
      send(VEC[k][15:8], int'(VEC[k][7:4]), 1'b0);
      check_regs(tag);
      check_ram(tag);
    end

    // R3: nothing before the strobe rises, effect after
    shift_bits(8'hC3, 8, 1'b0);
    tick(12);
    chk("R3", "ctrl before strobe rise", int'(ctrl_word), m_ctrl);
    load = 1'b1;
    tick(6);
    model_apply(8'hC3, 8);
    chk("R3", "ctrl after strobe rise", int'(ctrl_word), 3);

    // R1: data flipped while clock high is not the sampled value
    send(8'hD6, 8, 1'b1);
    chk("R1", "ctrl with data changing during clock high", int'(ctrl_word), 22);

    // R1: clock edges while strobe high change nothing
    for (int i = 0; i < 6; i++) begin
      sdat = i[0];
      tick(3); sclk = 1'b1; tick(3); sclk = 1'b0;
    end
    tick(6);
    check_regs("R1 edges while strobe high");
    check_ram("R1 edges while strobe high");
    send(8'hA4, 8, 1'b0);
    chk("R1", "address after edges while strobe high", int'(cur_addr), 4);

    // R9: out-of-range reads and reads during a shift
    @(negedge clk); rd_char = 4'd3; rd_row = 3'd5; #1;
    chk("R9", "row 5 read", int'(rd_cols), 0);
    @(negedge clk); rd_char = 4'd10; rd_row = 3'd0; #1;
    chk("R9", "char 10 read", int'(rd_cols), 0);
    @(negedge clk); rd_char = 4'd15; rd_row = 3'd7; #1;
    chk("R9", "char 15 row 7 read", int'(rd_cols), 0);
    @(negedge clk); rd_char = 4'd3; rd_row = 3'd4;
    shift_bits(8'h8A, 4, 1'b0);
    #1;
    chk("R9", "read during shift", int'(rd_cols), m_mem[3][4]);
    load = 1'b1;
    tick(6);
    chk("R9 R8", "read after 4-edge window", int'(rd_cols), m_mem[3][4]);

    // R10: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    model_reset();
    check_regs("R10 mid-run");
    check_ram("R10 mid-run");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule